// File: doc/BRIEF.md
# Ternary Column-Compression Multiplier

This block multiplies two unsigned ternary numbers of `N` trits each (6 by default) and returns their full product as `2N` trits. Every trit travels as a 2-bit code: `00` is 0, `01` is 1 and `10` is 2. Code `11` is not a legal trit on any port.

The arithmetic has three steps and no clock inside it. First, every pair of operand digits is multiplied, giving a product trit in the digit's column and a carry term in the column above. That carry term is 1 only when both digits are 2. Next, the terms in each column are compressed in Wallace-style stages of ternary half adders and reduced full adders, until no column holds more than two terms. A reduced full adder is one whose third input is never 2. Finally, a ternary ripple adder sums the two rows that remain.

The result is captured in a single output register, which has a valid/ready handshake on each side. An operand pair is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. A pending result stays unchanged on `out_prod` until `out_ready` is seen high with `out_valid`. The block can therefore accept one operand pair per cycle under full throughput.

Top module: `tern_mult`

## Requirements
- R1: Decoding `out_prod` trit by trit (trit i at bits [2i+1:2i], weight 3^i) gives exactly the integer product of the decoded `op_a` and `op_b`.
- R2: Trit codes are `00`=0, `01`=1, `10`=2. While `out_valid` is high, no trit of `out_prod` carries code `11`.
- R3: A digit pair contributes (a·b) mod 3 in its own column and floor(a·b/3) in the next column. For example, 2×2 yields the trits `11` in base 3 (decimal 4).
- R4: Every full adder in the reduction receives a term restricted to {0,1} in its third slot, and that slot never holds the value 2.
- R5: The product fits in 2N trits. No carry leaves column 2N-1, including when both operands are all 2s (the maximum).
- R6: `in_ready` is high in any cycle in which the output register is empty or `out_ready` is high.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_prod` does not change.
- R8: The cycle after an operand pair is accepted, `out_valid` is high and `out_prod` shows that pair's product.
- R9: During and right after reset, `out_valid` is low and `in_ready` is high.
- R10: A zero operand gives an all-zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair on `op_a`/`op_b` is valid |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| op_a | input | 2N | Multiplicand, N trits, 2 bits each |
| op_b | input | 2N | Multiplier, N trits, 2 bits each |
| out_valid | output | 1 | `out_prod` holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_prod | output | 4N | Product, 2N trits, 2 bits each |

## Verification
The checker watches four things on every cycle: the {0,1} slot of each reduction full adder, the carry leaving the top column, the trit codes on the output, and the handshake (acceptance leads to valid, a stalled result is held, an empty register is ready). Whether the product is numerically right can only be shown by the bench's scenarios. These compare every cycle against an integer model driven with zero operands, 2×2 digits, all-2 operands, an exhaustive sweep of the two low trits, long stalls and random traffic with random back-pressure.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t TZ = 2'b00;
  localparam trit_t TO = 2'b01;
  localparam trit_t TT = 2'b10;

  // Sum of three trits: returns {carry, sum}
  function automatic logic [3:0] t_add3(trit_t x, trit_t y, trit_t z);
    logic [2:0] s;
    s = {1'b0, x} + {1'b0, y} + {1'b0, z};
    if (s >= 3'd6)      t_add3 = {TT, 2'(s - 3'd6)};
    else if (s >= 3'd3) t_add3 = {TO, 2'(s - 3'd3)};
    else                t_add3 = {TZ, s[1:0]};
  endfunction

  // Single-digit product: returns {carry, product}
  function automatic logic [3:0] t_mul1(trit_t x, trit_t y);
    logic [3:0] p;
    p = {2'b00, x} * {2'b00, y};
    if (p >= 4'd3) t_mul1 = {TO, 2'(p - 4'd3)};
    else           t_mul1 = {TZ, p[1:0]};
  endfunction
endpackage

// File: rtl/tern_ppgen.sv
module tern_ppgen
  import tern_pkg::*;
#(
  parameter int N = 6
) (
  input  logic [N-1:0][1:0]   a,
  input  logic [N-1:0][1:0]   b,
  output logic [N*N-1:0][1:0] pp_lo,
  output logic [N*N-1:0][1:0] pp_hi
);
  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      logic [3:0] r;
      assign r              = t_mul1(a[i], b[j]);
      assign pp_lo[i*N + j] = r[1:0];
      assign pp_hi[i*N + j] = r[3:2];
    end
  end
endmodule

// File: rtl/tern_reduce.sv
module tern_reduce
  import tern_pkg::*;
#(
  parameter int N = 6
) (
  input  logic [N*N-1:0][1:0]   pp_lo,
  input  logic [N*N-1:0][1:0]   pp_hi,
  output logic [2*N-1:0][1:0]   row0,
  output logic [2*N-1:0][1:0]   row1,
  output logic                  slot_bad,
  output logic                  top_spill
);
  localparam int COLS   = 2 * N;
  localparam int DEPTH  = 2 * N;
  localparam int STAGES = 2 * N;
  localparam int DW     = $clog2(DEPTH);
  localparam int CW     = $clog2(COLS);

  always_comb begin
    trit_t      cv [COLS][DEPTH];
    logic       cn [COLS][DEPTH];
    int         cc [COLS];
    trit_t      nv [COLS][DEPTH];
    logic       nn [COLS][DEPTH];
    int         nc [COLS];
    trit_t      wv [DEPTH];
    trit_t      qv [DEPTH];
    int         wc, qc, wi, qi;
    trit_t      x, y, z;
    logic [3:0] r;

    slot_bad  = 1'b0;
    top_spill = 1'b0;
    x = TZ; y = TZ; z = TZ; r = '0;
    wc = 0; qc = 0; wi = 0; qi = 0;
    for (int c = 0; c < COLS; c++) begin
      cc[c] = 0;
      nc[c] = 0;
      for (int d = 0; d < DEPTH; d++) begin
        cv[c][d] = TZ; cn[c][d] = 1'b0;
        nv[c][d] = TZ; nn[c][d] = 1'b0;
      end
    end
    for (int d = 0; d < DEPTH; d++) begin
      wv[d] = TZ; qv[d] = TZ;
    end

    // Load digit products (wide) and their carries (narrow, one column up)
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        cv[CW'(i+j)][DW'(cc[i+j])] = pp_lo[i*N + j];
        cn[CW'(i+j)][DW'(cc[i+j])] = 1'b0;
        cc[i+j] = cc[i+j] + 1;
        cv[CW'(i+j+1)][DW'(cc[i+j+1])] = pp_hi[i*N + j];
        cn[CW'(i+j+1)][DW'(cc[i+j+1])] = 1'b1;
        cc[i+j+1] = cc[i+j+1] + 1;
      end
    end

    // Wallace stages: each stage reads cv and writes nv
    for (int st = 0; st < STAGES; st++) begin
      for (int c = 0; c < COLS; c++) begin
        nc[c] = 0;
      end
      for (int c = 0; c < COLS; c++) begin
        wc = 0; qc = 0; wi = 0; qi = 0;
        for (int d = 0; d < DEPTH; d++) begin
          if (d < cc[c]) begin
            if (cn[c][d]) begin qv[DW'(qc)] = cv[c][d]; qc = qc + 1; end
            else          begin wv[DW'(wc)] = cv[c][d]; wc = wc + 1; end
          end
        end
        if (cc[c] > 2) begin
          for (int k = 0; k < DEPTH; k++) begin
            if ((wc - wi) + (qc - qi) >= 3) begin
              if (qc - qi >= 1) begin
                // reduced full adder: restricted slot fed from a narrow term
                z = qv[DW'(qi)]; qi = qi + 1;
                if (wi < wc) begin x = wv[DW'(wi)]; wi = wi + 1; end
                else         begin x = qv[DW'(qi)]; qi = qi + 1; end
                if (wi < wc) begin y = wv[DW'(wi)]; wi = wi + 1; end
                else         begin y = qv[DW'(qi)]; qi = qi + 1; end
                if (z == TT) slot_bad = 1'b1;
              end else begin
                // half adder on two wide terms
                x = wv[DW'(wi)]; y = wv[DW'(wi+1)]; wi = wi + 2;
                z = TZ;
              end
              r = t_add3(x, y, z);
              nv[CW'(c)][DW'(nc[c])] = r[1:0];
              nn[CW'(c)][DW'(nc[c])] = 1'b0;
              nc[c] = nc[c] + 1;
              if (c + 1 < COLS) begin
                nv[CW'(c+1)][DW'(nc[c+1])] = r[3:2];
                nn[CW'(c+1)][DW'(nc[c+1])] = 1'b1;
                nc[c+1] = nc[c+1] + 1;
              end else if (r[3:2] != TZ) begin
                top_spill = 1'b1;
              end
            end
          end
        end
        // pass through what is left
        for (int k = 0; k < DEPTH; k++) begin
          if (k >= wi && k < wc) begin
            nv[CW'(c)][DW'(nc[c])] = wv[DW'(k)];
            nn[CW'(c)][DW'(nc[c])] = 1'b0;
            nc[c] = nc[c] + 1;
          end
        end
        for (int k = 0; k < DEPTH; k++) begin
          if (k >= qi && k < qc) begin
            nv[CW'(c)][DW'(nc[c])] = qv[DW'(k)];
            nn[CW'(c)][DW'(nc[c])] = 1'b1;
            nc[c] = nc[c] + 1;
          end
        end
      end
      for (int c = 0; c < COLS; c++) begin
        cc[c] = nc[c];
        for (int d = 0; d < DEPTH; d++) begin
          cv[c][d] = nv[c][d];
          cn[c][d] = nn[c][d];
        end
      end
    end

    for (int c = 0; c < COLS; c++) begin
      row0[c] = (cc[c] > 0) ? cv[c][0] : TZ;
      row1[c] = (cc[c] > 1) ? cv[c][1] : TZ;
    end
  end
endmodule

// File: rtl/tern_rca.sv
module tern_rca
  import tern_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0][1:0] x,
  input  logic [W-1:0][1:0] y,
  output logic [W-1:0][1:0] s,
  output logic [1:0]        cout
);
  logic [W:0][1:0] cy;
  assign cy[0] = TZ;

  for (genvar i = 0; i < W; i++) begin : g_dig
    logic [3:0] r;
    assign r       = t_add3(x[i], y[i], cy[i]);
    assign s[i]    = r[1:0];
    assign cy[i+1] = r[3:2];
  end

  assign cout = cy[W];
endmodule

// File: rtl/tern_mult.sv
module tern_mult
  import tern_pkg::*;
#(
  parameter int N = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [2*N-1:0] op_a,
  input  logic [2*N-1:0] op_b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [4*N-1:0] out_prod
);
  localparam int COLS = 2 * N;

  logic [N-1:0][1:0]    a_t, b_t;
  logic [N*N-1:0][1:0]  pp_lo, pp_hi;
  logic [COLS-1:0][1:0] row0, row1, sum_t;
  logic [1:0]           rca_cout;
  logic                 slot_bad, top_spill, msb_ovf;

  assign a_t = op_a;
  assign b_t = op_b;

  tern_ppgen #(.N(N)) u_pp (
    .a(a_t), .b(b_t), .pp_lo(pp_lo), .pp_hi(pp_hi)
  );

  tern_reduce #(.N(N)) u_red (
    .pp_lo(pp_lo), .pp_hi(pp_hi), .row0(row0), .row1(row1),
    .slot_bad(slot_bad), .top_spill(top_spill)
  );

  tern_rca #(.W(COLS)) u_rca (
    .x(row0), .y(row1), .s(sum_t), .cout(rca_cout)
  );

  assign msb_ovf  = top_spill | (rca_cout != TZ);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_prod  <= sum_t;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tern_mult_chk.sv
module tern_mult_chk #(
  parameter int N = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [4*N-1:0] out_prod,
  input logic           slot_bad,
  input logic           msb_ovf
);
  logic bad_code;
  always_comb begin
    bad_code = 1'b0;
    for (int i = 0; i < 2*N; i++) begin
      if (out_prod[2*i +: 2] == 2'b11) bad_code = 1'b1;
    end
  end

  // R4
  narrow_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !slot_bad);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !msb_ovf);

  // R2
  out_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !bad_code);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_prod)));

  // R8
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R6
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind tern_mult tern_mult_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_prod(out_prod),
  .slot_bad(slot_bad), .msb_ovf(msb_ovf)
);

// File: tb/tern_mult_tb.sv
`timescale 1ns/1ps
module tern_mult_tb;
  localparam int N    = 6;
  localparam int MAXV = 728; // 3^6 - 1

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid, out_ready;
  logic [2*N-1:0] op_a, op_b;
  logic           in_ready, out_valid;
  logic [4*N-1:0] out_prod;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string tag     = "R1";

  // behavioural model state
  bit    m_valid;
  longint m_prod;
  int    cur_a, cur_b;

  always #4 clk = ~clk;

  tern_mult #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_prod(out_prod)
  );

  function automatic logic [4*N-1:0] enc(longint v, int nt);
    logic [4*N-1:0] r;
    longint t;
    r = '0;
    t = v;
    for (int i = 0; i < nt; i++) begin
      r[2*i +: 2] = 2'(t % 3);
      t = t / 3;
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_prod  <= 0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      m_valid <= 1'b1;
      m_prod  <= longint'(cur_a) * longint'(cur_b);
    end else if (out_ready) begin
      m_valid <= 1'b0;
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit iv, int a, int b, bit ordy);
    bit bad;
    @(negedge clk);
    // R8: valid follows acceptance, R1/R3/R5/R7/R10 via current tag
    check(out_valid == m_valid, "R8", "out_valid", longint'(out_valid), longint'(m_valid));
    if (m_valid) begin
      check(out_prod == enc(m_prod, 2*N), tag, "out_prod",
            longint'(out_prod), longint'(enc(m_prod, 2*N)));
      bad = 0;
      for (int i = 0; i < 2*N; i++) if (out_prod[2*i +: 2] == 2'b11) bad = 1;
      check(!bad, "R2", "trit code", longint'(out_prod), 0);
    end
    in_valid  = iv;
    out_ready = ordy;
    cur_a     = a;
    cur_b     = b;
    op_a      = enc(longint'(a), N)[2*N-1:0];
    op_b      = enc(longint'(b), N)[2*N-1:0];
    #1;
    // R6: ready whenever empty or draining
    check(in_ready == (!m_valid || ordy), "R6", "in_ready",
          longint'(in_ready), longint'(!m_valid || ordy));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    op_a = '0; op_b = '0; cur_a = 0; cur_b = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0, "R9", "out_valid in reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R9", "in_ready in reset", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid after reset", longint'(out_valid), 0);

    tag = "R10";
    step(1, 0, 517, 1);
    step(1, 728, 0, 1);
    step(1, 0, 0, 1);

    tag = "R3";
    step(1, 2, 2, 1);
    step(1, 2, 1, 1);
    step(1, 1, 2, 1);
    step(1, 8, 8, 1);

    tag = "R4/R5";
    step(1, MAXV, MAXV, 1);
    step(1, MAXV, 1, 1);
    step(1, MAXV, 2, 1);

    tag = "R1";
    for (int a = 0; a < 9; a++)
      for (int b = 0; b < 9; b++)
        step(1, a, b, 1);

    tag = "R7";
    step(1, 400, 611, 0);
    step(1, 12, 13, 0);
    step(0, 0, 0, 0);
    step(1, 99, 98, 0);
    step(1, 5, 7, 1);
    step(0, 0, 0, 1);

    tag = "R1";
    for (int k = 0; k < 1500; k++)
      step(1'($urandom_range(0, 1)), int'($urandom_range(0, MAXV)),
           int'($urandom_range(0, MAXV)), 1'($urandom_range(0, 3) != 0));

    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule